// File: doc/BRIEF.md
# Conditional Skip Evaluation Unit

This block belongs to the execute stage of a small 8-bit interpreter core that uses 16-bit instructions. It decides whether the instruction after the current one must be passed over. The inputs are the instruction's top nibble, its low byte, the two operand register values (called vX and vY), and a 16-bit vector that holds one pressed flag per key. The block combines the three kinds of skip test into a single adjust value: compare against an immediate, compare one register with another, and test the key state. That adjust is 2 when the skip is taken and 0 when it is not.

The decision is combinational. The block also holds the program counter register. On each cycle where the execute strobe is high, that register loads the normally advanced PC supplied by the caller plus the adjust value, wrapping at 16 bits. The block also reports a malformed opcode whenever an instruction in one of the skip families carries a sub-field that has no meaning. Such an opcode never skips.

Top module: `skip_unit`

## Requirements
- R1: With top nibble 3, the adjust is 2 exactly when vX equals the low byte, and 0 otherwise.
- R2: With top nibble 4, the adjust is 2 exactly when vX differs from the low byte, and 0 otherwise.
- R3: With top nibble 5 and low nibble 0, the adjust is 2 exactly when vX equals vY. With top nibble 5 and any nonzero low nibble, `bad_op` is 1 and the adjust is 0.
- R4: With top nibble 9 and low nibble 0, the adjust is 2 exactly when vX differs from vY. With top nibble 9 and any nonzero low nibble, `bad_op` is 1 and the adjust is 0.
- R5: With top nibble E and low byte 9E, the adjust is 2 exactly when key bit `keys[vX[3:0]]` is 1. The upper four bits of vX play no part in this test.
- R6: With top nibble E and low byte A1, the adjust is 2 exactly when `keys[vX[3:0]]` is 0. With top nibble E and any other low byte, `bad_op` is 1 and the adjust is 0.
- R7: For every top nibble other than 3, 4, 5, 9 and E, the adjust is 0 and `bad_op` is 0.
- R8: On a rising edge where `exec_en` is 1, `pc_q` becomes (`pc_next` + adjust) mod 65536. On a rising edge where `exec_en` is 0, `pc_q` keeps its value.
- R9: On a rising edge where `rst` is 1, `pc_q` is cleared to 0, whatever the value of `exec_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_en | input | 1 | Execute strobe; loads the PC register |
| op_hi | input | 4 | Top nibble of the instruction |
| op_lo | input | 8 | Low byte of the instruction |
| vx | input | 8 | Value of the first operand register |
| vy | input | 8 | Value of the second operand register |
| keys | input | 16 | Key pressed flags, one bit per key |
| pc_next | input | 16 | Normally advanced program counter |
| skip_amt | output | 16 | Extra PC advance: 2 on skip, otherwise 0 |
| bad_op | output | 1 | Skip-family opcode with a meaningless sub-field |
| pc_q | output | 16 | Registered program counter |

## Verification
The hardest cases to reach are the ones where the answer depends on two separate inputs at once. The key tests need both a value of vX and a key pattern. The skip that crosses the top of the address space needs both a taken skip and a `pc_next` near 0xFFFF. The stimulus table places vX values whose upper nibble is nonzero against a single pressed bit, so that any decoder that uses the full byte gives a wrong result. It also places an all-ones key vector against a released bit 15. Separate directed tests apply a skip at `pc_next` = 0xFFFE and at 0xFFFF, so the wrapped results are visible on `pc_q`.

// File: rtl/skip_pkg.sv
package skip_pkg;

    localparam int PC_W   = 16;
    localparam int DATA_W = 8;
    localparam int KEYS   = 16;
    localparam int KIDX_W = $clog2(KEYS);
    localparam int STEP   = 2;

    // Top nibbles of the skip families; the order has no effect on the decision
    typedef enum logic [3:0] {
        FAM_EQ_IMM  = 4'h3,
        FAM_NE_IMM  = 4'h4,
        FAM_EQ_REG  = 4'h5,
        FAM_NE_REG  = 4'h9,
        FAM_KEYTEST = 4'hE
    } family_e;

    localparam logic [7:0] SEL_KEY_DOWN = 8'h9E;
    localparam logic [7:0] SEL_KEY_UP   = 8'hA1;

    typedef struct packed {
        logic take;
        logic bad;
    } verdict_t;

    function automatic logic fam_is_skip(input logic [3:0] hi);
        return (hi == FAM_EQ_IMM) || (hi == FAM_NE_IMM) || (hi == FAM_EQ_REG) ||
               (hi == FAM_NE_REG) || (hi == FAM_KEYTEST);
    endfunction

endpackage

// File: rtl/skip_decide.sv
module skip_decide
    import skip_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NK = KEYS
) (
    input  logic [3:0]    op_hi,
    input  logic [7:0]    op_lo,
    input  logic [DW-1:0] vx,
    input  logic [DW-1:0] vy,
    input  logic [NK-1:0] keys,
    output verdict_t      verdict
);
    localparam int IW = $clog2(NK);

    logic          key_hit;
    logic [3:0]    sub_n;
    logic [DW-1:0] imm;

    // Only the low index bits of vX pick the key
    assign key_hit = keys[vx[IW-1:0]];
    assign sub_n   = op_lo[3:0];
    assign imm     = DW'(op_lo);

    always_comb begin
        verdict = '0;
        case (op_hi)
            FAM_EQ_IMM: verdict.take = (vx == imm);
            FAM_NE_IMM: verdict.take = (vx != imm);
            FAM_EQ_REG: begin
                if (sub_n == 4'h0) verdict.take = (vx == vy);
                else               verdict.bad  = 1'b1;
            end
            FAM_NE_REG: begin
                if (sub_n == 4'h0) verdict.take = (vx != vy);
                else               verdict.bad  = 1'b1;
            end
            FAM_KEYTEST: begin
                if (op_lo == SEL_KEY_DOWN)    verdict.take = key_hit;
                else if (op_lo == SEL_KEY_UP) verdict.take = !key_hit;
                else                          verdict.bad  = 1'b1;
            end
            default: verdict = '0;
        endcase
    end

endmodule

// File: rtl/pc_step.sv
module pc_step
    import skip_pkg::*;
#(
    parameter int W = PC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] base,
    input  logic         take,
    output logic [W-1:0] pc_q
);
    localparam logic [W-1:0] EXTRA = W'(STEP);

    always_ff @(posedge clk) begin
        if (rst)       pc_q <= '0;
        else if (load) pc_q <= base + (take ? EXTRA : '0);
    end

    // R9: reset clears the PC even while the execute strobe is high
    p_reset_clear_r9: assert property (@(posedge clk) rst |=> pc_q == '0)
        else $error("p_reset_clear_r9");

    // R8: with the strobe low the PC holds
    p_pc_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(pc_q))
        else $error("p_pc_hold_r8");

endmodule

// File: rtl/skip_unit.sv
module skip_unit
    import skip_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              exec_en,
    input  logic [3:0]        op_hi,
    input  logic [7:0]        op_lo,
    input  logic [DATA_W-1:0] vx,
    input  logic [DATA_W-1:0] vy,
    input  logic [KEYS-1:0]   keys,
    input  logic [PC_W-1:0]   pc_next,
    output logic [PC_W-1:0]   skip_amt,
    output logic              bad_op,
    output logic [PC_W-1:0]   pc_q
);
    verdict_t verdict;

    skip_decide #(.DW(DATA_W), .NK(KEYS)) u_decide (
        .op_hi   (op_hi),
        .op_lo   (op_lo),
        .vx      (vx),
        .vy      (vy),
        .keys    (keys),
        .verdict (verdict)
    );

    assign skip_amt = verdict.take ? PC_W'(STEP) : '0;
    assign bad_op   = verdict.bad;

    pc_step #(.W(PC_W)) u_pc (
        .clk  (clk),
        .rst  (rst),
        .load (exec_en),
        .base (pc_next),
        .take (verdict.take),
        .pc_q (pc_q)
    );

    // R3/R4/R6: a malformed sub-field never produces a skip
    p_bad_blocks_skip_r3: assert property (@(posedge clk) disable iff (rst)
        bad_op |-> skip_amt == '0)
        else $error("p_bad_blocks_skip_r3");

    // R7: opcodes outside the skip families stay quiet
    p_quiet_family_r7: assert property (@(posedge clk) disable iff (rst)
        !fam_is_skip(op_hi) |-> (!bad_op && skip_amt == '0))
        else $error("p_quiet_family_r7");

    // R1: an immediate match under family 3 must skip
    p_eq_imm_r1: assert property (@(posedge clk) disable iff (rst)
        (op_hi == 4'h3 && vx == op_lo) |-> skip_amt == PC_W'(STEP))
        else $error("p_eq_imm_r1");

    // R8: a strobe loads the supplied next PC plus the adjust
    p_pc_load_r8: assert property (@(posedge clk) disable iff (rst)
        exec_en |=> pc_q == $past(pc_next + skip_amt))
        else $error("p_pc_load_r8");

endmodule

// File: tb/skip_unit_test.sv
module skip_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exec_en = 1'b0;
    logic [3:0]  op_hi = '0;
    logic [7:0]  op_lo = '0;
    logic [7:0]  vx = '0;
    logic [7:0]  vy = '0;
    logic [15:0] keys = '0;
    logic [15:0] pc_next = '0;
    logic [15:0] skip_amt;
    logic        bad_op;
    logic [15:0] pc_q;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    skip_unit uut (
        .clk(clk), .rst(rst), .exec_en(exec_en), .op_hi(op_hi), .op_lo(op_lo),
        .vx(vx), .vy(vy), .keys(keys), .pc_next(pc_next),
        .skip_amt(skip_amt), .bad_op(bad_op), .pc_q(pc_q)
    );

    typedef struct packed {
        logic [3:0]  hi;
        logic [7:0]  lo;
        logic [7:0]  x;
        logic [7:0]  y;
        logic [15:0] k;
        logic        skip;
        logic        bad;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{4'h3, 8'h5A, 8'h5A, 8'h00, 16'h0000, 1'b1, 1'b0},
        '{4'h3, 8'h5A, 8'h5B, 8'h00, 16'h0000, 1'b0, 1'b0},
        '{4'h4, 8'h00, 8'h01, 8'h00, 16'h0000, 1'b1, 1'b0},
        '{4'h4, 8'hFF, 8'hFF, 8'h00, 16'h0000, 1'b0, 1'b0},
        '{4'h5, 8'h30, 8'h07, 8'h07, 16'h0000, 1'b1, 1'b0},
        '{4'h5, 8'h31, 8'h07, 8'h07, 16'h0000, 1'b0, 1'b1},
        '{4'h5, 8'h20, 8'h07, 8'h08, 16'h0000, 1'b0, 1'b0},
        '{4'h9, 8'h40, 8'h01, 8'h02, 16'h0000, 1'b1, 1'b0},
        '{4'h9, 8'h40, 8'h03, 8'h03, 16'h0000, 1'b0, 1'b0},
        '{4'h9, 8'h4F, 8'h01, 8'h02, 16'h0000, 1'b0, 1'b1},
        '{4'hE, 8'h9E, 8'h03, 8'h00, 16'h0008, 1'b1, 1'b0},
        '{4'hE, 8'h9E, 8'hF3, 8'h00, 16'h0008, 1'b1, 1'b0},
        '{4'hE, 8'h9E, 8'h04, 8'h00, 16'h0008, 1'b0, 1'b0},
        '{4'hE, 8'hA1, 8'h0F, 8'h00, 16'h7FFF, 1'b1, 1'b0},
        '{4'hE, 8'hA1, 8'h0F, 8'h00, 16'hFFFF, 1'b0, 1'b0},
        '{4'hE, 8'h9F, 8'h00, 8'h00, 16'hFFFF, 1'b0, 1'b1},
        '{4'h1, 8'h00, 8'h00, 8'h00, 16'h0000, 1'b0, 1'b0},
        '{4'h6, 8'h00, 8'h00, 8'h00, 16'hFFFF, 1'b0, 1'b0},
        '{4'hF, 8'h9E, 8'h00, 8'h00, 16'hFFFF, 1'b0, 1'b0},
        '{4'h0, 8'h30, 8'h30, 8'h30, 16'h0000, 1'b0, 1'b0}
    };

    function automatic string req_of(input logic [3:0] hi, input logic [7:0] lo);
        case (hi)
            4'h3: return "R1";
            4'h4: return "R2";
            4'h5: return "R3";
            4'h9: return "R4";
            4'hE: return (lo == 8'h9E) ? "R5" : "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R8 watchdog: actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R9: reset wins over a high strobe
        exec_en = 1'b1;
        pc_next = 16'h1234;
        op_hi = 4'h3; op_lo = 8'h00; vx = 8'h00;
        repeat (3) @(negedge clk);
        chk("R9", "pc after reset", pc_q, 16'h0000);
        exec_en = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk("R9", "pc held after reset", pc_q, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            logic [15:0] base;
            base = 16'h0200 + 16'(i) * 16'h0111;
            op_hi = VEC[i].hi; op_lo = VEC[i].lo;
            vx = VEC[i].x; vy = VEC[i].y; keys = VEC[i].k;
            pc_next = base;
            exec_en = 1'b1;
            #5;
            chk(req_of(VEC[i].hi, VEC[i].lo), "adjust", skip_amt,
                VEC[i].skip ? 16'd2 : 16'd0);
            chk(req_of(VEC[i].hi, VEC[i].lo), "bad_op", {15'd0, bad_op},
                {15'd0, VEC[i].bad});
            @(negedge clk);
            exec_en = 1'b0;
            chk("R8", "pc load", pc_q, base + (VEC[i].skip ? 16'd2 : 16'd0));
        end

        // R8: wrap across the top of the address space
        op_hi = 4'h3; op_lo = 8'h11; vx = 8'h11;
        pc_next = 16'hFFFE; exec_en = 1'b1;
        @(negedge clk);
        chk("R8", "wrap FFFE", pc_q, 16'h0000);
        pc_next = 16'hFFFF;
        @(negedge clk);
        chk("R8", "wrap FFFF", pc_q, 16'h0001);

        // R8: with the strobe low, new inputs must not move the PC
        exec_en = 1'b0;
        pc_next = 16'h0ABC; op_hi = 4'h4; op_lo = 8'h00; vx = 8'h99;
        repeat (3) @(negedge clk);
        chk("R8", "hold without strobe", pc_q, 16'h0001);

        // R5: upper nibble of vX ignored for a released key
        op_hi = 4'hE; op_lo = 8'h9E; vx = 8'hA2; keys = 16'hFFFB;
        #5;
        chk("R5", "upper nibble ignored", skip_amt, 16'd0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule